// File: doc/BRIEF.md
# Capability Exception Cause Unit

This block records capability faults. When the raise strobe is high, it turns the fault kind into an 8-bit cause code. It formats the faulting register number into an 8-bit field and writes both into a 16-bit cause register on the next clock edge. Call and return traps are sent to their own exception class. Every other fault goes to the general capability-error class. The choice of class appears as a one-cycle pulse on one of two outputs in the cycle after the raise.

A fault that names no register writes 0xFF as its register field. An access-system-registers fault on the invoked-data register (register 26) is recorded as a separate code. A separate combinational path answers whether a queried capability register may be accessed. The answer depends on the system-register permission of the current PC capability and on the call-delay flag.

Top module: `cap_cause_unit`

## Requirements
- R1: After a synchronous reset, `cause_q` is 0x0000 and both pulse outputs are low.
- R2: `code_o` is the code for the fault kind index on `kind_i`:
  - Indices 0..10 give codes 0x00..0x0A, in the order none, length, tag, seal, type, call trap, return trap, stack underflow, user-defined, no-store-cap page, inexact bounds.
  - Indices 11..21 give codes 0x10..0x1A, in the order global, execute, load, store, load-cap, store-cap, store-local-cap, seal permission, system-register access, call permission, invoked-data access.
  - Indices 22..31 give 0x00.
- R3: On a clock edge with `raise_i` high, `cause_q` becomes {code in bits 15:8, register field in bits 7:0}. Without `raise_i`, `cause_q` holds its value.
- R4: The register field is `regnum_i` zero-extended to 8 bits. When `noreg_i` is high, the register field is 0xFF.
- R5: A system-register access fault (index 19) with `regnum_i`=26 and `noreg_i` low produces code 0x1A. With any other register, or with `noreg_i` high, it produces 0x18.
- R6: The cycle after a raise, `trap_pulse_o` is high for kinds 5 and 6, and `cap_err_pulse_o` is high for all other kinds. Each pulse lasts one cycle, and the two are never high together.
- R7: `access_ok_o` is low for `query_reg_i`=26 while `ccall_delay_i` is high.
- R8: `access_ok_o` is low for `query_reg_i` 27..31 while `sysreg_perm_i` is low. It is high for registers 0..25 always, for 26 when there is no delay, and for 27..31 when the permission is set.
- R9: A raise with kind "none" (index 0) still writes the cause register, which then reads {0x00, register field}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | Record the current fault request this cycle |
| kind_i | input | 5 | Fault kind index |
| regnum_i | input | 5 | Faulting register number |
| noreg_i | input | 1 | Fault has no associated register |
| sysreg_perm_i | input | 1 | Current PC capability grants system-register access |
| ccall_delay_i | input | 1 | Call-delay window active |
| query_reg_i | input | 5 | Register number for the access check |
| code_o | output | 8 | Cause code for the current request (combinational) |
| cause_q | output | 16 | Cause register |
| trap_pulse_o | output | 1 | One-cycle trap-class exception pulse |
| cap_err_pulse_o | output | 1 | One-cycle general capability-error pulse |
| access_ok_o | output | 1 | Queried register may be accessed |

## Verification
The remap case is the hardest to reach. It needs the system-register access kind together with register 26 and the no-register flag low. Any one of those off must leave code 0x18. The stimulus sweeps that kind against register 25, register 26 and the no-register flag. Separately, it runs all 22 kinds back to back without idle cycles. This shows that each pulse lasts one cycle even when raises are consecutive.

// File: rtl/cap_cause_pkg.sv
package cap_cause_pkg;
  localparam int KIND_W  = 5;
  localparam int CODE_W  = 8;
  localparam int N_BASIC = 11;
  localparam int N_KINDS = 22;
  localparam int PERM_BASE = 16;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE       = 5'd0,
    FK_CALL_TRAP  = 5'd5,
    FK_RET_TRAP   = 5'd6,
    FK_SYSREG     = 5'd19,
    FK_IDC_ACCESS = 5'd21
  } fault_kind_e;

  function automatic logic [CODE_W-1:0] kind_code(input logic [KIND_W-1:0] k);
    logic [CODE_W-1:0] c;
    if (int'(k) < N_BASIC)
      c = CODE_W'(k);
    else if (int'(k) < N_KINDS)
      c = CODE_W'(int'(k) - N_BASIC + PERM_BASE);
    else
      c = '0;
    return c;
  endfunction
endpackage

// File: rtl/cxu_encode.sv
module cxu_encode
  import cap_cause_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int IDC_REG = 26
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [REG_W-1:0]  regnum_i,
  input  logic              noreg_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] regfield_o,
  output logic              is_trap_o
);
  localparam int PAD_W = CODE_W - REG_W;

  logic on_idc;
  assign on_idc = !noreg_i && (int'(regnum_i) == IDC_REG);

  always_comb begin
    if (kind_i == FK_SYSREG && on_idc)
      code_o = kind_code(FK_IDC_ACCESS);
    else
      code_o = kind_code(kind_i);
  end

  assign regfield_o = noreg_i ? {CODE_W{1'b1}} : {{PAD_W{1'b0}}, regnum_i};
  assign is_trap_o  = (kind_i == FK_CALL_TRAP) || (kind_i == FK_RET_TRAP);
endmodule

// File: rtl/cxu_access.sv
module cxu_access #(
  parameter int REG_W      = 5,
  parameter int IDC_REG    = 26,
  parameter int SYS_REG_LO = 27
) (
  input  logic [REG_W-1:0] query_reg_i,
  input  logic             sysreg_perm_i,
  input  logic             ccall_delay_i,
  output logic             access_ok_o
);
  localparam int N_REGS = 1 << REG_W;

  logic [N_REGS-1:0] ok_vec;

  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_reg
      if (g == IDC_REG) begin : g_idc
        assign ok_vec[g] = !ccall_delay_i;
      end else if (g >= SYS_REG_LO) begin : g_sys
        assign ok_vec[g] = sysreg_perm_i;
      end else begin : g_plain
        assign ok_vec[g] = 1'b1;
      end
    end
  endgenerate

  assign access_ok_o = ok_vec[query_reg_i];
endmodule

// File: rtl/cxu_cause_reg.sv
module cxu_cause_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] regfield_i,
  input  logic              is_trap_i,
  output logic [2*CODE_W-1:0] cause_q,
  output logic              trap_pulse_o,
  output logic              cap_err_pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q         <= '0;
      trap_pulse_o    <= 1'b0;
      cap_err_pulse_o <= 1'b0;
    end else begin
      if (raise_i) cause_q <= {code_i, regfield_i};
      trap_pulse_o    <= raise_i && is_trap_i;
      cap_err_pulse_o <= raise_i && !is_trap_i;
    end
  end
endmodule

// File: rtl/cap_cause_unit.sv
module cap_cause_unit
  import cap_cause_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int IDC_REG    = 26,
  parameter int SYS_REG_LO = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [REG_W-1:0]  regnum_i,
  input  logic              noreg_i,
  input  logic              sysreg_perm_i,
  input  logic              ccall_delay_i,
  input  logic [REG_W-1:0]  query_reg_i,
  output logic [CODE_W-1:0] code_o,
  output logic [2*CODE_W-1:0] cause_q,
  output logic              trap_pulse_o,
  output logic              cap_err_pulse_o,
  output logic              access_ok_o
);
  logic [CODE_W-1:0] regfield;
  logic              is_trap;

  cxu_encode #(.REG_W(REG_W), .IDC_REG(IDC_REG)) u_encode (
    .kind_i(kind_i), .regnum_i(regnum_i), .noreg_i(noreg_i),
    .code_o(code_o), .regfield_o(regfield), .is_trap_o(is_trap)
  );

  cxu_cause_reg #(.CODE_W(CODE_W)) u_cause (
    .clk(clk), .rst(rst), .raise_i(raise_i), .code_i(code_o),
    .regfield_i(regfield), .is_trap_i(is_trap), .cause_q(cause_q),
    .trap_pulse_o(trap_pulse_o), .cap_err_pulse_o(cap_err_pulse_o)
  );

  cxu_access #(.REG_W(REG_W), .IDC_REG(IDC_REG), .SYS_REG_LO(SYS_REG_LO)) u_access (
    .query_reg_i(query_reg_i), .sysreg_perm_i(sysreg_perm_i),
    .ccall_delay_i(ccall_delay_i), .access_ok_o(access_ok_o)
  );
endmodule

// File: rtl/cap_cause_unit_chk.sv
module cap_cause_unit_chk #(
  parameter int REG_W = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        raise_i,
  input logic        noreg_i,
  input logic        sysreg_perm_i,
  input logic        ccall_delay_i,
  input logic [REG_W-1:0] query_reg_i,
  input logic [15:0] cause_q,
  input logic        trap_pulse_o,
  input logic        cap_err_pulse_o,
  input logic        access_ok_o
);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !raise_i |=> $stable(cause_q));

  p_noreg_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (raise_i && noreg_i) |=> (cause_q[7:0] == 8'hFF));

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(trap_pulse_o && cap_err_pulse_o));

  p_pulse_after_raise_r6: assert property (@(posedge clk) disable iff (rst)
    raise_i |=> (trap_pulse_o || cap_err_pulse_o));

  p_no_idle_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !raise_i |=> !(trap_pulse_o || cap_err_pulse_o));

  p_delay_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (ccall_delay_i && int'(query_reg_i) == 26) |-> !access_ok_o);

  p_low_regs_open_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(query_reg_i) < 26) |-> access_ok_o);

  p_sys_needs_perm_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(query_reg_i) >= 27 && !sysreg_perm_i) |-> !access_ok_o);
endmodule

bind cap_cause_unit cap_cause_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .raise_i(raise_i), .noreg_i(noreg_i),
  .sysreg_perm_i(sysreg_perm_i), .ccall_delay_i(ccall_delay_i),
  .query_reg_i(query_reg_i), .cause_q(cause_q), .trap_pulse_o(trap_pulse_o),
  .cap_err_pulse_o(cap_err_pulse_o), .access_ok_o(access_ok_o)
);

// File: tb/test_cap_cause_unit.sv
`timescale 1ns/1ps
module test_cap_cause_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raise_i = 1'b0;
  logic [4:0] kind_i = '0;
  logic [4:0] regnum_i = '0;
  logic noreg_i = 1'b0;
  logic sysreg_perm_i = 1'b0;
  logic ccall_delay_i = 1'b0;
  logic [4:0] query_reg_i = '0;
  logic [7:0] code_o;
  logic [15:0] cause_q;
  logic trap_pulse_o, cap_err_pulse_o, access_ok_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cap_cause_unit i_cap_cause_unit (
    .clk(clk), .rst(rst), .raise_i(raise_i), .kind_i(kind_i),
    .regnum_i(regnum_i), .noreg_i(noreg_i), .sysreg_perm_i(sysreg_perm_i),
    .ccall_delay_i(ccall_delay_i), .query_reg_i(query_reg_i),
    .code_o(code_o), .cause_q(cause_q), .trap_pulse_o(trap_pulse_o),
    .cap_err_pulse_o(cap_err_pulse_o), .access_ok_o(access_ok_o)
  );

  logic [7:0] exp_codes [22] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
    8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14,
    8'h15, 8'h16, 8'h17, 8'h18, 8'h19, 8'h1A};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a raise at negedge, then check the code, the cause register and the pulses.
  task automatic raise_one(input int k, input int r, input logic nr,
                           input logic [7:0] ecode, input logic [7:0] ereg, input string req);
    logic etrap;
    @(negedge clk);
    raise_i = 1'b1; kind_i = 5'(k); regnum_i = 5'(r); noreg_i = nr;
    #1 check({req, " code"}, 32'(code_o), 32'(ecode));
    @(posedge clk); #1;
    raise_i = 1'b0;
    etrap = (k == 5 || k == 6);
    check({req, " cause"}, 32'(cause_q), {16'h0, ecode, ereg});
    check("R6 trap pulse", 32'(trap_pulse_o), 32'(etrap));
    check("R6 err pulse", 32'(cap_err_pulse_o), 32'(!etrap));
  endtask

  task automatic t_reset;
    check("R1 cause reset", 32'(cause_q), 32'h0);
    check("R1 trap reset", 32'(trap_pulse_o), 32'h0);
    check("R1 err reset", 32'(cap_err_pulse_o), 32'h0);
  endtask

  task automatic t_all_codes;
    for (int k = 0; k < 22; k++)
      raise_one(k, k % 26, 1'b0, exp_codes[k], 8'(k % 26), "R2");
    @(posedge clk); #1;
    check("R6 pulse one cycle trap", 32'(trap_pulse_o), 32'h0);
    check("R6 pulse one cycle err", 32'(cap_err_pulse_o), 32'h0);
  endtask

  task automatic t_unused_codes;
    for (int k = 22; k < 32; k++) begin
      @(negedge clk); kind_i = 5'(k); noreg_i = 1'b0; regnum_i = 5'd3;
      #1 check("R2 unused index", 32'(code_o), 32'h0);
    end
  endtask

  task automatic t_regfield;
    raise_one(1, 31, 1'b0, 8'h01, 8'h1F, "R4 zero-extend");
    raise_one(2, 7, 1'b1, 8'h02, 8'hFF, "R4 noreg");
    raise_one(5, 0, 1'b1, 8'h05, 8'hFF, "R4 noreg trap");
  endtask

  task automatic t_remap;
    raise_one(19, 26, 1'b0, 8'h1A, 8'h1A, "R5 remap on 26");
    raise_one(19, 25, 1'b0, 8'h18, 8'h19, "R5 no remap on 25");
    raise_one(19, 26, 1'b1, 8'h18, 8'hFF, "R5 no remap noreg");
    raise_one(18, 26, 1'b0, 8'h17, 8'h1A, "R5 other kind on 26");
  endtask

  task automatic t_hold_and_none;
    raise_one(0, 9, 1'b0, 8'h00, 8'h09, "R9 none writes");
    raise_one(3, 4, 1'b0, 8'h03, 8'h04, "R3 write");
    @(negedge clk); kind_i = 5'd10; regnum_i = 5'd12; noreg_i = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R3 hold without raise", 32'(cause_q), 32'h0304);
    check("R6 no pulse idle", 32'(trap_pulse_o | cap_err_pulse_o), 32'h0);
  endtask

  task automatic t_access;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 32; r++) begin
        logic eok;
        @(negedge clk);
        sysreg_perm_i = c[0]; ccall_delay_i = c[1]; query_reg_i = 5'(r);
        if (r == 26) eok = !c[1];
        else if (r >= 27) eok = c[0];
        else eok = 1'b1;
        #1 check(r == 26 ? "R7 idc access" : "R8 reg access", 32'(access_ok_o), 32'(eok));
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst = 1'b0;
    t_all_codes();
    t_unused_codes();
    t_regfield();
    t_remap();
    t_hold_and_none();
    t_access();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule